// File: doc/BRIEF.md
# Loop Predicate Generator

This block builds the lane predicate for one step of a vectorised counted loop. It receives a starting count and a bound, both scalars. It also receives three selects: one for the operand width, one for the kind of comparison and one for the element size. It then walks the lanes of a 128-bit vector one at a time, starting from the lowest. For each lane it compares the running count with the bound and then adds one to the count. A lane is live only while every comparison so far has held. As soon as one comparison fails, that lane and every lane above it are dead.

The count is kept modulo the selected operand width. In 32-bit mode, a count that passes the largest positive value turns negative when it is read as signed. A loop that runs near the top of the signed range therefore keeps all of its lanes live. Along with the predicate, the block derives four condition flags.

A one-cycle `start` pulse launches an operation. The block takes one clock per lane. It raises `done` for one cycle when the operation ends, and its results then hold until the next launch.

Top module: `lane_pred_gen`

## Requirements
- R1: `cmp_kind` selects the comparison of count against bound: 0 signed less-or-equal, 1 unsigned lower, 2 unsigned lower-or-same, 3 signed less-than.
- R2: `wide_op`=1 makes both operands 64 bits wide. `wide_op`=0 makes them 32 bits wide, and bits 63:32 of both `start_val` and `bound_val` then have no effect on any output.
- R3: Before each comparison the count is reduced modulo 2^width. In 32-bit mode a count of 0xFFFFFFFF becomes 0 on the next lane.
- R4: A signed comparison reads both the count and the bound as two's-complement values of the operand width. With 32-bit operands, a start of 0x7FFFFFFD, a bound of 0x7FFFFFFF, kind 0 and byte elements, all 16 lanes are live.
- R5: Lane i is live only if the comparison held for lane i and for every lower lane. A comparison that holds again after an earlier failure does not revive the lane.
- R6: The count rises by exactly one per lane, whatever the element size.
- R7: `elem_size` sets the lane count: 0 gives 16 lanes, 1 gives 8, 2 gives 4 and 3 gives 2. Lane i is reported on `pred` bit i<<`elem_size`, and every other `pred` bit is 0.
- R8: The flags are set as follows. `flag_n` is set when lane 0 is live. `flag_z` is set when no lane is live. `flag_c` is set when the highest lane of the current element size is dead. `flag_v` is always 0.
- R9: A `start` accepted at clock edge k raises `done` for exactly one cycle, right after edge k+lanes. `busy` is high from edge k+1 until that same edge. Afterwards `pred` and the flags hold until the next accepted start.
- R10: A `start` pulse while `busy` is high has no effect. The running operation completes with the operands it was launched with.
- R11: After reset `busy` and `done` are 0, `pred` is 0, `flag_z` and `flag_c` are 1, and `flag_n` and `flag_v` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse, accepted only when idle |
| wide_op | input | 1 | 1: 64-bit operands, 0: 32-bit operands |
| cmp_kind | input | 2 | Comparison kind (R1 encoding) |
| elem_size | input | 2 | Element size: 0 byte, 1 half, 2 word, 3 double |
| start_val | input | 64 | Starting count |
| bound_val | input | 64 | Loop bound |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| pred | output | 16 | Predicate, one bit per vector byte |
| flag_n | output | 1 | Lane 0 live |
| flag_z | output | 1 | No lane live |
| flag_c | output | 1 | Highest lane dead |
| flag_v | output | 1 | Always 0 |

## Verification
Every combination of width, comparison kind and element size is run over a set of operand pairs. The pairs are chosen so that each one separates a different behaviour:
- Counts just below the signed maximum show the signed wrap that keeps lanes live.
- Counts just below the unsigned maximum show the unsigned wrap.
- Equal operands separate the inclusive kinds from the strict ones.
- A pair whose condition fails on one lane and holds again on the next shows whether lane activity is cumulative.
- Garbage in the upper operand halves under 32-bit mode shows whether those bits leak into the result.

Directed runs cover the reset values, a start pulse in mid-operation, and outputs that must hold steady while the block is idle.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

  localparam int OPW = 64;

  typedef enum logic [1:0] {
    CMP_SLE = 2'd0,
    CMP_ULO = 2'd1,
    CMP_ULS = 2'd2,
    CMP_SLT = 2'd3
  } cmp_kind_e;

  // Mask covering the active operand width.
  function automatic logic [OPW-1:0] width_mask(input logic wide);
    return wide ? {OPW{1'b1}} : {{(OPW-32){1'b0}}, 32'hFFFF_FFFF};
  endfunction

  // Two's-complement reinterpretation at the selected width.
  function automatic logic signed [OPW-1:0] as_signed(input logic [OPW-1:0] v,
                                                      input logic wide);
    return wide ? $signed(v) : $signed({{(OPW-32){v[31]}}, v[31:0]});
  endfunction

  // Does the loop condition hold for this count against this bound?
  function automatic logic lane_holds(input cmp_kind_e kind, input logic wide,
                                      input logic [OPW-1:0] cnt,
                                      input logic [OPW-1:0] bnd);
    logic [OPW-1:0] uc, ub;
    logic signed [OPW-1:0] sc, sb;
    uc = cnt & width_mask(wide);
    ub = bnd & width_mask(wide);
    sc = as_signed(uc, wide);
    sb = as_signed(bnd, wide);
    case (kind)
      CMP_SLE: return sc <= sb;
      CMP_ULO: return uc < ub;
      CMP_ULS: return uc <= ub;
      default: return sc < sb;
    endcase
  endfunction

endpackage

// File: rtl/lpg_lane_eval.sv
module lpg_lane_eval
  import lpg_pkg::*;
(
  input  cmp_kind_e        kind,
  input  logic             wide,
  input  logic [OPW-1:0]   cnt,
  input  logic [OPW-1:0]   bnd,
  output logic             holds
);
  always_comb holds = lane_holds(kind, wide, cnt, bnd);
endmodule

// File: rtl/lpg_sequencer.sv
module lpg_sequencer
  import lpg_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  localparam int LIDX_W = $clog2(VEC_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide_in,
  input  cmp_kind_e         kind_in,
  input  logic [1:0]        esize_in,
  input  logic [OPW-1:0]    a_in,
  input  logic [OPW-1:0]    b_in,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic              last_lane,
  output logic [LIDX_W-1:0] lane_idx,
  output logic [OPW-1:0]    cnt,
  output logic [OPW-1:0]    bnd,
  output logic              wide_q,
  output cmp_kind_e         kind_q,
  output logic [1:0]        esize_q
);
  logic [LIDX_W:0] n_lanes;

  always_comb begin
    accept    = start && !busy;
    n_lanes   = (LIDX_W+1)'(VEC_BYTES) >> esize_q;
    last_lane = busy && ({1'b0, lane_idx} == n_lanes - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      lane_idx <= '0;
      cnt      <= '0;
      bnd      <= '0;
      wide_q   <= 1'b0;
      kind_q   <= CMP_SLE;
      esize_q  <= 2'd0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        lane_idx <= '0;
        cnt      <= a_in & width_mask(wide_in);
        bnd      <= b_in;
        wide_q   <= wide_in;
        kind_q   <= kind_in;
        esize_q  <= esize_in;
      end else if (busy) begin
        cnt      <= (cnt + 1'b1) & width_mask(wide_q);
        lane_idx <= lane_idx + 1'b1;
        if (last_lane) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lpg_pred_pack.sv
module lpg_pred_pack #(
  parameter int VEC_BYTES = 16,
  localparam int LIDX_W = $clog2(VEC_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic                 busy,
  input  logic                 holds,
  input  logic [LIDX_W-1:0]    lane_idx,
  input  logic [1:0]           esize_q,
  output logic [VEC_BYTES-1:0] pred,
  output logic [VEC_BYTES-1:0] slot_mask,
  output logic                 alive,
  output logic                 flag_n,
  output logic                 flag_z,
  output logic                 flag_c,
  output logic                 flag_v
);
  logic [LIDX_W-1:0] pos;
  logic [LIDX_W-1:0] top_pos;
  logic              alive_nx;

  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_slot
    always_comb slot_mask[b] = ((b & ((1 << esize_q) - 1)) == 0);
  end

  always_comb begin
    pos      = lane_idx << esize_q;
    top_pos  = LIDX_W'(VEC_BYTES - (1 << esize_q));
    alive_nx = alive && holds;
    flag_n   = pred[0];
    flag_z   = (pred == '0);
    flag_c   = !pred[top_pos];
    flag_v   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred  <= '0;
      alive <= 1'b0;
    end else if (accept) begin
      pred  <= '0;
      alive <= 1'b1;
    end else if (busy) begin
      pred[pos] <= alive_nx;
      alive     <= alive_nx;
    end
  end
endmodule

// File: rtl/lane_pred_gen.sv
module lane_pred_gen
  import lpg_pkg::*;
#(
  parameter int VEC_BYTES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 wide_op,
  input  logic [1:0]           cmp_kind,
  input  logic [1:0]           elem_size,
  input  logic [63:0]          start_val,
  input  logic [63:0]          bound_val,
  output logic                 busy,
  output logic                 done,
  output logic [VEC_BYTES-1:0] pred,
  output logic                 flag_n,
  output logic                 flag_z,
  output logic                 flag_c,
  output logic                 flag_v
);
  localparam int LIDX_W = $clog2(VEC_BYTES);

  logic              accept_w;
  logic              last_lane_w;
  logic [LIDX_W-1:0] lane_idx_w;
  logic [OPW-1:0]    cnt_w;
  logic [OPW-1:0]    bnd_w;
  logic              wide_q_w;
  cmp_kind_e         kind_q_w;
  logic [1:0]        esize_q_w;
  logic              holds_w;
  logic              alive_w;
  logic [VEC_BYTES-1:0] slot_mask_w;

  lpg_sequencer #(.VEC_BYTES(VEC_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .wide_in(wide_op), .kind_in(cmp_kind_e'(cmp_kind)), .esize_in(elem_size),
    .a_in(start_val), .b_in(bound_val),
    .accept(accept_w), .busy(busy), .done(done), .last_lane(last_lane_w),
    .lane_idx(lane_idx_w), .cnt(cnt_w), .bnd(bnd_w),
    .wide_q(wide_q_w), .kind_q(kind_q_w), .esize_q(esize_q_w)
  );

  lpg_lane_eval u_eval (
    .kind(kind_q_w), .wide(wide_q_w), .cnt(cnt_w), .bnd(bnd_w), .holds(holds_w)
  );

  lpg_pred_pack #(.VEC_BYTES(VEC_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .accept(accept_w), .busy(busy), .holds(holds_w),
    .lane_idx(lane_idx_w), .esize_q(esize_q_w),
    .pred(pred), .slot_mask(slot_mask_w), .alive(alive_w),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );
endmodule

// File: rtl/lpg_checker.sv
module lpg_checker #(
  parameter int VEC_BYTES = 16,
  localparam int LIDX_W = $clog2(VEC_BYTES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic [VEC_BYTES-1:0] pred,
  input logic [VEC_BYTES-1:0] slot_mask,
  input logic                 alive,
  input logic                 last_lane,
  input logic [LIDX_W-1:0]    lane_idx,
  input logic                 wide_q,
  input logic [63:0]          cnt,
  input logic                 flag_n,
  input logic                 flag_z,
  input logic                 flag_c
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) && !busy);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(pred));

  assert_dead_stays_dead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !alive) |=> !alive);

  assert_slots_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pred & ~slot_mask) == '0);

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_lane) |=> busy && (lane_idx == $past(lane_idx) + 1'b1));

  assert_ctr_in_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wide_q) |-> (cnt[63:32] == 32'd0));

  assert_flags_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z |-> (!flag_n && flag_c));
endmodule

bind lane_pred_gen lpg_checker #(.VEC_BYTES(VEC_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .pred(pred), .slot_mask(slot_mask_w), .alive(alive_w),
  .last_lane(last_lane_w), .lane_idx(lane_idx_w), .wide_q(wide_q_w),
  .cnt(cnt_w), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
);

// File: tb/test_lane_pred_gen.sv
module test_lane_pred_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wide_op = 1'b0;
  logic [1:0]  cmp_kind = 2'd0;
  logic [1:0]  elem_size = 2'd0;
  logic [63:0] start_val = '0;
  logic [63:0] bound_val = '0;
  logic        busy, done, flag_n, flag_z, flag_c, flag_v;
  logic [15:0] pred;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_pred_gen i_lane_pred_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_op(wide_op),
    .cmp_kind(cmp_kind), .elem_size(elem_size), .start_val(start_val),
    .bound_val(bound_val), .busy(busy), .done(done), .pred(pred),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: count kept in native-width variables, wrap by natural overflow.
  function automatic logic [15:0] model(input bit w, input int k, input int es,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [15:0] p = '0;
    bit live = 1;
    bit c;
    for (int ln = 0; ln < (16 >> es); ln++) begin
      if (w) begin
        logic [63:0] x = a + 64'(ln);
        case (k)
          0: c = $signed(x) <= $signed(b);
          1: c = x < b;
          2: c = x <= b;
          default: c = $signed(x) < $signed(b);
        endcase
      end else begin
        logic [31:0] x = a[31:0] + 32'(ln);
        case (k)
          0: c = $signed(x) <= $signed(b[31:0]);
          1: c = x < b[31:0];
          2: c = x <= b[31:0];
          default: c = $signed(x) < $signed(b[31:0]);
        endcase
      end
      live = live && c;
      p[ln * (1 << es)] = live;
    end
    return p;
  endfunction

  task automatic launch(input bit w, input int k, input int es,
                        input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    wide_op = w; cmp_kind = 2'(k); elem_size = 2'(es);
    start_val = a; bound_val = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Waits for done; returns number of negedges seen after the accepting edge.
  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_and_check(input bit w, input int k, input int es,
                               input logic [63:0] a, input logic [63:0] b,
                               input string tag);
    int cyc;
    logic [15:0] e;
    int n = 16 >> es;
    e = model(w, k, es, a, b);
    launch(w, k, es, a, b);
    chk(busy === 1'b1, "R9 busy after start", 64'(busy), 64'd1);
    wait_done(cyc);
    chk(cyc == n + 1, "R9 done timing", 64'(cyc), 64'(n + 1));
    chk(pred === e, {"R1 R3 R4 R5 R6 R7 pred ", tag}, 64'(pred), 64'(e));
    chk(flag_n === e[0], "R8 flag_n", 64'(flag_n), 64'(e[0]));
    chk(flag_z === (e == 0), "R8 flag_z", 64'(flag_z), 64'(e == 0));
    chk(flag_c === !e[16 - (1 << es)], "R8 flag_c", 64'(flag_c), 64'(!e[16 - (1 << es)]));
    chk(flag_v === 1'b0, "R8 flag_v", 64'(flag_v), 64'd0);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R9 done one cycle", 64'(done), 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] a32 [7];
    logic [63:0] b32 [7];
    logic [63:0] a64 [5];
    logic [63:0] b64 [5];
    logic [15:0] held;
    int cyc;

    a32 = '{64'h7FFF_FFFD, 64'hFFFF_FFFD, 64'h0, 64'h5, 64'h7FFF_FFFE,
            64'hDEAD_BEEF_7FFF_FFFD, 64'h3};
    b32 = '{64'h7FFF_FFFF, 64'h2, 64'h5, 64'h5, 64'h7FFF_FFFF,
            64'h1234_0000_7FFF_FFFF, 64'h5};
    a64 = '{64'h7FFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFD, 64'h0,
            64'h5, 64'h0000_0000_FFFF_FFFE};
    b64 = '{64'h7FFF_FFFF_FFFF_FFFF, 64'h3, 64'h5, 64'h5, 64'h0000_0001_0000_0002};

    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy === 0 && done === 0, "R11 busy/done", {busy, done}, 64'd0);
    chk(pred === 16'h0, "R11 pred", 64'(pred), 64'd0);
    chk({flag_n, flag_z, flag_c, flag_v} === 4'b0110, "R11 flags",
        64'({flag_n, flag_z, flag_c, flag_v}), 64'h6);
    rst_n = 1'b1;

    // R4 signed wrap case
    run_and_check(1'b0, 0, 0, 64'h7FFF_FFFD, 64'h7FFF_FFFF, "signed wrap");
    chk(pred === 16'hFFFF, "R4 all lanes live", 64'(pred), 64'hFFFF);

    // R2 upper halves ignored in 32-bit mode
    run_and_check(1'b0, 3, 0, 64'hFFFF_0000_7FFF_FFFE, 64'h0000_FFFF_7FFF_FFFF, "upper");
    chk(pred === 16'h0001, "R2 upper bits ignored, R5 no revival", 64'(pred), 64'h0001);

    // Sweep
    for (int w = 0; w < 2; w++)
      for (int k = 0; k < 4; k++)
        for (int es = 0; es < 4; es++) begin
          if (w == 0)
            for (int i = 0; i < 7; i++) run_and_check(1'b0, k, es, a32[i], b32[i], "sweep32");
          else
            for (int i = 0; i < 5; i++) run_and_check(1'b1, k, es, a64[i], b64[i], "sweep64");
        end

    // R10 start while busy ignored
    launch(1'b0, 1, 0, 64'h0, 64'h3);
    @(negedge clk);
    wide_op = 1'b1; cmp_kind = 2'd2; start_val = 64'h0; bound_val = 64'hFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    chk(pred === 16'h0007, "R10 start ignored while busy", 64'(pred), 64'h0007);

    // R9 hold while idle
    held = pred;
    wide_op = 1'b1; start_val = 64'h0; bound_val = 64'hFF;
    repeat (5) @(negedge clk);
    chk(pred === held && busy === 0, "R9 idle hold", 64'(pred), 64'(held));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule